// File: doc/BRIEF.md
# Routed Interrupt Controller

The block gathers 32 interrupt request wires and presents them as a 4 by 4 grid of parent interrupt lines, one group of four for each of four cores. Every request passes through a two-stage synchroniser. Its trigger type is set by one bit in an edge register and one bit in a polarity register. The result is gated by a per-source enable and then steered by a per-source routing byte to one or more (core, parent line) targets. Each parent output is registered.

Software programs the block over a simple register bus with a request strobe, a write flag, byte enables and a 32-bit data word. The routing bytes are packed four to a word at the bottom of the map, so each can be written alone with a single byte enable. The enable mask is changed through separate set and clear words, so no read-modify-write cycle is needed. Edge-captured requests stay pending until software writes a one to the matching bit of the status word.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, the enable mask, the polarity word, the edge word and every routing byte read as zero, and all 16 outputs `irq_o` are low.
- R2: The routing byte of source n lives at byte offset n (word `n/4`, byte lane `n%4`, bits `[8*(n%4)+7 : 8*(n%4)]`), and writes honour `be_i` per lane. In that byte, bit `4+p` selects parent line p and bit c selects core c.
- R3: Writing to offset 0x28 sets every enable bit whose data bit is 1, and leaves bits written as 0 unchanged.
- R4: Writing to offset 0x2C clears every enable bit whose data bit is 1, and leaves bits written as 0 unchanged. Writing all ones disables every source.
- R5: A read of offset 0x24 returns the current enable mask. Every read returns its data on `rdata_o` one clock after the request cycle, and `rdata_o` is zero otherwise.
- R6: Offset 0x30 holds the polarity word and offset 0x34 holds the edge word. Both are read/write with per-lane `be_i`. An edge bit of 0 selects level mode and 1 selects edge mode. A polarity bit of 1 selects active-high or rising, and 0 selects active-low or falling.
- R7: Offset 0x40 reads the status word. For a level-mode source, the status bit equals the synchronised input if its polarity bit is 1, and the inverted input if it is 0.
- R8: An edge-mode source sets its pending bit on the selected edge only, and holds it after the input returns. Writing 1 to that bit at 0x40 clears it, and writing 0 does not. A source switched to level mode loses its pending bit.
- R9: Output `irq_o[4*c+p]` is high while at least one source is enabled, has status 1, and has both bit c and bit `4+p` set in its routing byte. A disabled source or a zero routing byte drives nothing.
- R10: A routing byte with several core bits and/or parent bits set drives every (core, parent) pair it selects.
- R11: In level mode, a change at `irq_i` reaches `irq_o` on the third rising clock edge. In edge mode, a captured edge reaches `irq_o` on the fourth rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| be_i | input | 4 | Byte lane enables for writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| irq_i | input | 32 | Interrupt request inputs, asynchronous |
| irq_o | output | 16 | Parent lines, index 4*core + parent |

## Verification
Embedded properties check the following on every cycle:
- a set write never clears an enable bit, and a full-word set or clear takes effect on the next cycle;
- a pending bit can only rise while its source is in edge mode;
- a held pending bit survives any cycle that does not write 1 to it;
- a level-mode source never keeps a pending bit;
- the outputs stay low after any cycle with the enable mask at zero.

Only the bench scenarios can show the following:
- the address layout of the routing bytes and the per-source target decoding, swept over all 32 sources;
- the effect of polarity on level status;
- the rejection of the wrong edge;
- the exact cycle on which an output changes.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int unsigned SRC_N   = 32;
  localparam int unsigned PAR_N   = 4;
  localparam int unsigned CORE_N  = 4;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned ROUTE_W = 8;
  localparam int unsigned PAR_LSB = 4;  // parent nibble starts here in a routing byte

  // word indices (byte offset / 4)
  localparam int unsigned W_EN   = 'h24 >> 2;
  localparam int unsigned W_SET  = 'h28 >> 2;
  localparam int unsigned W_CLR  = 'h2C >> 2;
  localparam int unsigned W_POL  = 'h30 >> 2;
  localparam int unsigned W_EDGE = 'h34 >> 2;
  localparam int unsigned W_STAT = 'h40 >> 2;

  function automatic logic [BUS_W-1:0] lane_mask(input logic [BUS_W/8-1:0] be);
    logic [BUS_W-1:0] m;
    for (int b = 0; b < BUS_W/8; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction
endpackage

// File: rtl/irc_sync.sv
module irc_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/irc_cond.sv
module irc_cond #(
  parameter int unsigned SRC_N = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] sync_i,
  input  logic [SRC_N-1:0] pol_i,
  input  logic [SRC_N-1:0] edge_i,
  input  logic [SRC_N-1:0] clr_i,
  output logic [SRC_N-1:0] status_o
);
  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    logic prev_q, pend_q, pend_d, level, hit;

    assign level = pol_i[i] ? sync_i[i] : ~sync_i[i];
    assign hit   = pol_i[i] ? (sync_i[i] & ~prev_q) : (~sync_i[i] & prev_q);

    always_comb begin
      pend_d = 1'b0;
      if (edge_i[i]) pend_d = hit | (pend_q & ~clr_i[i]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        prev_q <= sync_i[i];
        pend_q <= pend_d;
      end
    end

    assign status_o[i] = edge_i[i] ? pend_q : level;

    p_pend_rise_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_q) |-> $past(edge_i[i]));
    p_level_no_pend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !edge_i[i] |=> !pend_q);
    p_pend_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_i[i] && pend_q && !clr_i[i]) |=> pend_q);
  end
endmodule

// File: rtl/irc_regs.sv
module irc_regs
  import irc_pkg::*;
#(
  parameter int unsigned N_SRC  = SRC_N,
  parameter int unsigned A_W    = ADDR_W
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            req_i,
  input  logic                            we_i,
  input  logic [A_W-1:0]                  addr_i,
  input  logic [BUS_W/8-1:0]              be_i,
  input  logic [BUS_W-1:0]                wdata_i,
  output logic [BUS_W-1:0]                rdata_o,
  input  logic [N_SRC-1:0]                status_i,
  output logic [N_SRC-1:0][ROUTE_W-1:0]   route_o,
  output logic [N_SRC-1:0]                en_o,
  output logic [N_SRC-1:0]                pol_o,
  output logic [N_SRC-1:0]                edge_o,
  output logic [N_SRC-1:0]                stat_clr_o
);
  localparam int unsigned WI_W     = A_W - 2;
  localparam int unsigned LANES    = BUS_W / 8;
  localparam int unsigned RT_WORDS = N_SRC / LANES;

  logic [WI_W-1:0]  widx;
  logic             wr, rd;
  logic [BUS_W-1:0] bmask, wbits, rd_d, rdata_q;
  logic [N_SRC-1:0] en_q, pol_q, edge_q;
  logic             unused_addr;

  assign widx        = addr_i[A_W-1:2];
  assign unused_addr = ^addr_i[1:0];
  assign wr          = req_i & we_i;
  assign rd          = req_i & ~we_i;
  assign bmask       = lane_mask(be_i);
  assign wbits       = wdata_i & bmask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pol_q  <= '0;
      edge_q <= '0;
    end else if (wr) begin
      if (widx == WI_W'(W_SET)) en_q <= en_q | wbits[N_SRC-1:0];
      if (widx == WI_W'(W_CLR)) en_q <= en_q & ~wbits[N_SRC-1:0];
      if (widx == WI_W'(W_POL))
        pol_q <= (pol_q & ~bmask[N_SRC-1:0]) | wbits[N_SRC-1:0];
      if (widx == WI_W'(W_EDGE))
        edge_q <= (edge_q & ~bmask[N_SRC-1:0]) | wbits[N_SRC-1:0];
    end
  end

  assign stat_clr_o = (wr && widx == WI_W'(W_STAT)) ? wbits[N_SRC-1:0] : '0;

  for (genvar s = 0; s < N_SRC; s++) begin : g_route
    logic [ROUTE_W-1:0] rt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rt_q <= '0;
      else if (wr && widx == WI_W'(s / LANES) && be_i[s % LANES])
        rt_q <= wdata_i[(s % LANES)*8 +: 8];
    end
    assign route_o[s] = rt_q;
  end

  always_comb begin
    rd_d = '0;
    if (widx < WI_W'(RT_WORDS)) begin
      for (int s = 0; s < int'(N_SRC); s++)
        if (widx == WI_W'(s / LANES)) rd_d[(s % LANES)*8 +: 8] = route_o[s];
    end else if (widx == WI_W'(W_EN))   rd_d = BUS_W'(en_q);
    else if (widx == WI_W'(W_POL))      rd_d = BUS_W'(pol_q);
    else if (widx == WI_W'(W_EDGE))     rd_d = BUS_W'(edge_q);
    else if (widx == WI_W'(W_STAT))     rd_d = BUS_W'(status_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd ? rd_d : '0;
  end

  assign rdata_o = rdata_q;
  assign en_o    = en_q;
  assign pol_o   = pol_q;
  assign edge_o  = edge_q;

  p_set_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && widx == WI_W'(W_SET)) |=> ((en_q & $past(en_q)) == $past(en_q)));
  p_set_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && widx == WI_W'(W_SET) && be_i == '1)
      |=> ((en_q & $past(wdata_i[N_SRC-1:0])) == $past(wdata_i[N_SRC-1:0])));
  p_clr_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && widx == WI_W'(W_CLR) && be_i == '1)
      |=> ((en_q & $past(wdata_i[N_SRC-1:0])) == '0));
  p_rdata_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> (rdata_o == '0));
endmodule

// File: rtl/irc_route.sv
module irc_route
  import irc_pkg::*;
#(
  parameter int unsigned N_SRC  = SRC_N,
  parameter int unsigned N_PAR  = PAR_N,
  parameter int unsigned N_CORE = CORE_N
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_SRC-1:0]              en_i,
  input  logic [N_SRC-1:0]              status_i,
  input  logic [N_SRC-1:0][ROUTE_W-1:0] route_i,
  output logic [N_CORE*N_PAR-1:0]       irq_o
);
  localparam int unsigned OUT_N = N_CORE * N_PAR;

  logic [OUT_N-1:0] hit, irq_q;
  logic [N_SRC-1:0] live;

  assign live = en_i & status_i;

  always_comb begin
    hit = '0;
    for (int c = 0; c < int'(N_CORE); c++)
      for (int p = 0; p < int'(N_PAR); p++)
        for (int s = 0; s < int'(N_SRC); s++)
          if (live[s] && route_i[s][c] && route_i[s][PAR_LSB+p])
            hit[c*N_PAR+p] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= hit;
  end

  assign irq_o = irq_q;

  p_masked_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |=> (irq_o == '0));
  p_unrouted_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_i == '0) |=> (irq_o == '0));
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irc_pkg::*;
#(
  parameter int unsigned N_SRC  = SRC_N,
  parameter int unsigned N_PAR  = PAR_N,
  parameter int unsigned N_CORE = CORE_N,
  parameter int unsigned A_W    = ADDR_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [A_W-1:0]          addr_i,
  input  logic [BUS_W/8-1:0]      be_i,
  input  logic [BUS_W-1:0]        wdata_i,
  output logic [BUS_W-1:0]        rdata_o,
  input  logic [N_SRC-1:0]        irq_i,
  output logic [N_CORE*N_PAR-1:0] irq_o
);
  logic [N_SRC-1:0]              sync, status, en, pol, edge_sel, clr;
  logic [N_SRC-1:0][ROUTE_W-1:0] route;

  irc_sync #(.WIDTH(N_SRC)) i_sync (
    .clk_i, .rst_ni, .async_i(irq_i), .sync_o(sync)
  );

  irc_cond #(.SRC_N(N_SRC)) i_cond (
    .clk_i, .rst_ni, .sync_i(sync), .pol_i(pol), .edge_i(edge_sel),
    .clr_i(clr), .status_o(status)
  );

  irc_regs #(.N_SRC(N_SRC), .A_W(A_W)) i_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .be_i, .wdata_i, .rdata_o,
    .status_i(status), .route_o(route), .en_o(en), .pol_o(pol),
    .edge_o(edge_sel), .stat_clr_o(clr)
  );

  irc_route #(.N_SRC(N_SRC), .N_PAR(N_PAR), .N_CORE(N_CORE)) i_route (
    .clk_i, .rst_ni, .en_i(en), .status_i(status), .route_i(route), .irq_o
  );
endmodule

// File: tb/test_irq_route_ctrl.sv
`timescale 1ns/1ps
module test_irq_route_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] irq = '0;
  logic [15:0] irq_out;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_route_ctrl i_irq_route_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .irq_i(irq), .irq_o(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; be = b;
    @(negedge clk);
    req = 1'b0; we = 1'b0; be = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
    req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] rbyte(input int s);
    return 8'((1 << (4 + ((s >> 2) & 3))) | (1 << (s & 3)));
  endfunction

  function automatic int oidx(input int s);
    return (s & 3) * 4 + ((s >> 2) & 3);
  endfunction

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(8'h24, v); chk("R1 enable", v, 32'h0);
    rd(8'h30, v); chk("R1 polarity", v, 32'h0);
    rd(8'h34, v); chk("R1 edge", v, 32'h0);
    rd(8'h00, v); chk("R1 route", v, 32'h0);
    chk("R1 irq_o", 32'(irq_out), 32'h0);

    // R2 program every routing byte, read back
    for (int w = 0; w < 8; w++)
      wr(8'(w*4), {rbyte(4*w+3), rbyte(4*w+2), rbyte(4*w+1), rbyte(4*w)}, 4'hF);
    for (int w = 0; w < 8; w++) begin
      rd(8'(w*4), v);
      chk("R2 route word", v, {rbyte(4*w+3), rbyte(4*w+2), rbyte(4*w+1), rbyte(4*w)});
    end

    // R9 sweep: each source alone, level active-high
    wr(8'h30, 32'hFFFF_FFFF, 4'hF);
    wr(8'h28, 32'hFFFF_FFFF, 4'hF);
    for (int s = 0; s < 32; s++) begin
      irq = 32'(1) << s;
      idle(5);
      chk("R9 target", 32'(irq_out), 32'(1) << oidx(s));
      rd(8'h40, v); chk("R7 status high", v, 32'(1) << s);
    end
    irq = '0; idle(5);
    chk("R9 idle", 32'(irq_out), 32'h0);

    // R7 active-low
    wr(8'h30, 32'h0, 4'hF);
    idle(5);
    chk("R7 low all active", 32'(irq_out), 32'h0000_FFFF);
    rd(8'h40, v); chk("R7 low status", v, 32'hFFFF_FFFF);
    irq = 32'hFFFF_FFFF; idle(5);
    chk("R7 low all idle", 32'(irq_out), 32'h0);
    rd(8'h40, v); chk("R7 low status idle", v, 32'h0);
    irq = '0;

    // R6 per-lane polarity write
    wr(8'h30, 32'hFFFF_FFFF, 4'hF);
    wr(8'h30, 32'h0, 4'h1);
    rd(8'h30, v); chk("R6 pol lane", v, 32'hFFFF_FF00);
    wr(8'h30, 32'hFFFF_FFFF, 4'hF);

    // R3 R4 R5 enable set/clear
    wr(8'h2C, 32'hFFFF_FFFF, 4'hF);
    rd(8'h24, v); chk("R4 clear all", v, 32'h0);
    wr(8'h28, 32'h20, 4'hF);
    wr(8'h28, 32'h80, 4'hF);
    rd(8'h24, v); chk("R3 set keeps zeros", v, 32'hA0);
    wr(8'h2C, 32'h80, 4'hF);
    rd(8'h24, v); chk("R4 clear one", v, 32'h20);

    // R11 level latency, R9 disabled source 6 ignored
    idle(3);
    irq = 32'h60;
    idle(2); chk("R11 level before", 32'(irq_out), 32'h0);
    idle(1); chk("R11 level at 3", 32'(irq_out), 32'(1) << 5);
    idle(3); chk("R9 disabled ignored", 32'(irq_out), 32'(1) << 5);
    irq = '0; idle(4);

    // R10 multi-target via byte write of source 7
    wr(8'h04, 32'hF300_0000, 4'h8);
    rd(8'h04, v); chk("R2 byte lane", v, 32'hF324_2221);
    wr(8'h2C, 32'hFFFF_FFFF, 4'hF);
    wr(8'h28, 32'h80, 4'hF);
    irq = 32'h80; idle(5);
    chk("R10 multi", 32'(irq_out), 32'h0000_00FF);
    wr(8'h04, 32'h0, 4'h8);
    idle(3);
    chk("R9 zero route", 32'(irq_out), 32'h0);
    irq = '0; idle(4);

    // R8 edge mode, source 9 -> core1 parent2 -> bit 6
    wr(8'h2C, 32'hFFFF_FFFF, 4'hF);
    wr(8'h28, 32'h200, 4'hF);
    wr(8'h34, 32'h200, 4'hF);
    rd(8'h34, v); chk("R6 edge readback", v, 32'h200);
    idle(3);
    irq = 32'h200;
    idle(3); chk("R11 edge before", 32'(irq_out), 32'h0);
    idle(1); chk("R11 edge at 4", 32'(irq_out), 32'h40);
    irq = '0; idle(5);
    chk("R8 held", 32'(irq_out), 32'h40);
    rd(8'h40, v); chk("R8 status held", v, 32'h200);
    wr(8'h40, 32'hFFFF_FDFF, 4'hF);
    idle(3); chk("R8 zero no clear", 32'(irq_out), 32'h40);
    wr(8'h40, 32'h200, 4'hF);
    idle(4); chk("R8 w1c", 32'(irq_out), 32'h0);
    rd(8'h40, v); chk("R8 status cleared", v, 32'h0);

    // R8 falling edge only
    wr(8'h30, 32'hFFFF_FDFF, 4'hF);
    irq = 32'h200; idle(6);
    chk("R8 falling ignores rise", 32'(irq_out), 32'h0);
    irq = '0; idle(6);
    chk("R8 falling captured", 32'(irq_out), 32'h40);
    wr(8'h30, 32'hFFFF_FFFF, 4'hF);
    idle(3);
    wr(8'h34, 32'h0, 4'hF);
    idle(4);
    chk("R8 level drops pend", 32'(irq_out), 32'h0);
    wr(8'h34, 32'h200, 4'hF);
    idle(4);
    chk("R8 pend stays cleared", 32'(irq_out), 32'h0);
    rd(8'h40, v); chk("R8 status after mode", v, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule